// File: doc/BRIEF.md
# Vector Predicate Remap Unit

This unit turns a small table of predication settings into a per-register view that a vector pipeline can query quickly. Software fills up to 16 configuration slots. Each slot names a destination register, whether that register is in the integer or the floating-point class, and an integer register whose bits act as the element mask. Each slot also carries an invert flag and a zeroing flag. Every write to the table starts a rebuild. The rebuild clears two 32-slot lookup arrays, one per register class, and then walks the table from slot 0 to slot 15. Each written slot is copied into the array position its destination register selects.

For each vector element, the pipeline presents the operation class, the destination register and the element index. The unit looks up the redirection, sends the mask register number to the integer register file read port, and takes the element's bit from the returned word. It applies inversion and returns the predicate bit, the zeroing flag and an enabled flag one cycle later. While a rebuild is running, `busy` is high and queries are refused.

Top module: `vpred_remap`

## Requirements
- R1: A configuration word is 13 bits. Bits [4:0] give the destination register. Bit 5 gives the class (0 integer, 1 floating-point). Bit 6 is the invert flag and bit 7 is the zeroing flag. Bits [12:8] give the mask register. A word is stored into slot `cfg_idx` when `cfg_we` is high, and that slot becomes live.
- R2: After reset no slot is live. Every query returns `res_pred`=1, `res_zero`=0 and `res_en`=0, and `busy` and `res_valid` are low.
- R3: `busy` rises in the cycle after a configuration write and stays high for exactly 17 cycles. A write made during a rebuild restarts the 17-cycle count.
- R4: A query presented while `busy` is high produces no result (`res_valid` stays low).
- R5: A query accepted while `busy` is low produces `res_valid`=1 in the next cycle, together with its result.
- R6: The query class selects the array. An integer query sees only class-0 slots and a floating-point query sees only class-1 slots. `res_en`=1 exactly when a live slot of that class names the queried destination.
- R7: When enabled, `rf_raddr` carries the slot's mask register. `res_pred` equals bit `q_elem` of `rf_rdata` XOR the invert flag.
- R8: When enabled, `res_zero` equals the slot's zeroing flag.
- R9: When no slot is enabled for the queried register, `res_pred`=1 and `res_zero`=0, whatever the register file returns.
- R10: When several live slots of one class name the same destination, the highest-numbered slot decides the result.
- R11: Each rebuild starts from empty arrays. Rewriting a slot to a new destination removes its old mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration slot number |
| cfg_wdata | input | 13 | Configuration word (layout in R1) |
| busy | output | 1 | Rebuild in progress; queries are refused |
| q_valid | input | 1 | Query request |
| q_fp | input | 1 | Query class: 0 integer, 1 floating-point |
| q_rd | input | 5 | Destination register of the operation |
| q_elem | input | 5 | Element index |
| rf_raddr | output | 5 | Integer register file read address (mask register) |
| rf_rdata | input | 32 | Integer register file read data |
| res_valid | output | 1 | Result valid |
| res_pred | output | 1 | Predicate bit for the element |
| res_zero | output | 1 | Zeroing flag for the element |
| res_en | output | 1 | Predication enabled for the destination |

## Verification
The assertions check several properties on every cycle. A write must start a rebuild, and the walk must end with `busy` low. The clear step must empty both arrays. Results may only follow accepted queries, and a disabled result must always report predicate 1 with no zeroing. Other behaviour can only be shown by the bench's scenarios, which sweep every class, register and element against a model of the table: which slot wins when several name the same destination, the exact XOR against the selected mask bit, the separation between the two classes, and the removal of stale mappings after a rewrite.

// File: rtl/vpred_pkg.sv
package vpred_pkg;

  localparam int REG_W    = 5;
  localparam int NUM_REGS = 1 << REG_W;
  localparam int CFG_W    = 13;

  // configuration word field positions
  localparam int TGT_LSB  = 0;
  localparam int FP_BIT   = 5;
  localparam int INV_BIT  = 6;
  localparam int ZERO_BIT = 7;
  localparam int PIDX_LSB = 8;

  typedef struct packed {
    logic             zero;
    logic             inv;
    logic             is_fp;
    logic [REG_W-1:0] pidx;
    logic [REG_W-1:0] tgt;
  } cfg_ent_t;

  typedef struct packed {
    logic             en;
    logic             zero;
    logic             inv;
    logic [REG_W-1:0] pidx;
  } slot_t;

  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_CLEAR = 2'd1,
    RB_WALK  = 2'd2
  } rb_state_e;

  function automatic cfg_ent_t unpack_cfg(input logic [CFG_W-1:0] w);
    cfg_ent_t e;
    e.zero  = w[ZERO_BIT];
    e.inv   = w[INV_BIT];
    e.is_fp = w[FP_BIT];
    e.pidx  = w[PIDX_LSB +: REG_W];
    e.tgt   = w[TGT_LSB +: REG_W];
    return e;
  endfunction

endpackage

// File: rtl/vpred_rst_sync.sv
module vpred_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/vpred_cfg_table.sv
module vpred_cfg_table
  import vpred_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [CFG_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output cfg_ent_t         rd_ent,
  output logic             rd_live
);

  logic [CFG_W-1:0]       word_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] live_q;
  logic [NUM_ENTRIES-1:0] live_d;

  always_comb begin
    live_d = live_q;
    if (we) live_d[waddr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_d;
  end

  generate
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_word
      logic word_en;
      assign word_en = we && (waddr == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (word_en) word_q[g] <= wdata;
      end
    end
  endgenerate

  assign rd_ent  = unpack_cfg(word_q[rd_idx]);
  assign rd_live = live_q[rd_idx];

  // R1: a written slot becomes live and holds the written word
  p_write_marks_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (live_q[$past(waddr)] && word_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/vpred_rebuild.sv
module vpred_rebuild
  import vpred_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  cfg_ent_t         ent,
  input  logic             ent_live,
  output logic [IDX_W-1:0] walk_idx,
  output logic             busy,
  output slot_t            int_tab [NUM_REGS],
  output slot_t            fp_tab  [NUM_REGS]
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  rb_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  slot_t            int_q [NUM_REGS];
  slot_t            fp_q  [NUM_REGS];
  slot_t            int_d [NUM_REGS];
  slot_t            fp_d  [NUM_REGS];
  slot_t            new_slot;

  // sequencer next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (cfg_we) begin
      state_d = RB_CLEAR;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        RB_CLEAR: begin
          state_d = RB_WALK;
          idx_d   = '0;
        end
        RB_WALK: begin
          if (idx_q == LAST_IDX) state_d = RB_IDLE;
          else                   idx_d   = idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RB_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign new_slot = '{en: 1'b1, zero: ent.zero, inv: ent.inv, pidx: ent.pidx};

  // lookup arrays next state
  always_comb begin
    int_d = int_q;
    fp_d  = fp_q;
    if (state_q == RB_CLEAR) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        int_d[r] = '0;
        fp_d[r]  = '0;
      end
    end else if (state_q == RB_WALK && ent_live) begin
      if (ent.is_fp) fp_d[ent.tgt]  = new_slot;
      else           int_d[ent.tgt] = new_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        int_q[r] <= '0;
        fp_q[r]  <= '0;
      end
    end else begin
      int_q <= int_d;
      fp_q  <= fp_d;
    end
  end

  assign walk_idx = idx_q;
  assign busy     = (state_q != RB_IDLE);
  assign int_tab  = int_q;
  assign fp_tab   = fp_q;

  logic [NUM_REGS-1:0] en_vec_int, en_vec_fp;
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_envec
      assign en_vec_int[g] = int_q[g].en;
      assign en_vec_fp[g]  = fp_q[g].en;
    end
  endgenerate

  // R3: a write starts a rebuild in the next cycle
  p_write_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (busy && state_q == RB_CLEAR));

  // R3: the last walk step without a new write ends the rebuild
  p_walk_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RB_WALK && idx_q == LAST_IDX && !cfg_we) |=> !busy);

  // R11: the clear step leaves both arrays empty
  p_clear_wipes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RB_CLEAR) |=> (en_vec_int == '0 && en_vec_fp == '0));

  // R11: a walk step enables at most one slot
  p_walk_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RB_WALK && !cfg_we) |=>
      ($countones({en_vec_int, en_vec_fp}) <= $countones($past({en_vec_int, en_vec_fp})) + 1));

endmodule

// File: rtl/vpred_query.sv
module vpred_query
  import vpred_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int ELEM_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              q_valid,
  input  logic              q_fp,
  input  logic [REG_W-1:0]  q_rd,
  input  logic [ELEM_W-1:0] q_elem,
  input  slot_t             int_tab [NUM_REGS],
  input  slot_t             fp_tab  [NUM_REGS],
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              res_valid,
  output logic              res_pred,
  output logic              res_zero,
  output logic              res_en
);

  slot_t sel;
  logic  accept;
  logic  pred_d, zero_d, en_d, valid_d;
  logic  pred_q, zero_q, en_q, valid_q;

  assign sel      = q_fp ? fp_tab[q_rd] : int_tab[q_rd];
  assign rf_raddr = sel.pidx;
  assign accept   = q_valid && !busy;

  always_comb begin
    valid_d = accept;
    en_d    = sel.en;
    if (sel.en) begin
      pred_d = rf_rdata[q_elem] ^ sel.inv;
      zero_d = sel.zero;
    end else begin
      pred_d = 1'b1;
      zero_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pred_q <= pred_d;
      zero_q <= zero_d;
      en_q   <= en_d;
    end
  end

  assign res_valid = valid_q;
  assign res_pred  = pred_q;
  assign res_zero  = zero_q;
  assign res_en    = en_q;

  // R4 and R5: a result only follows a query accepted while idle
  p_result_needs_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(q_valid && !busy));

  // R5: an accepted query always yields a result
  p_accept_gives_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !busy) |=> res_valid);

  // R9: a disabled result executes every element with no zeroing
  p_disabled_passes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_en) |-> (res_pred && !res_zero));

endmodule

// File: rtl/vpred_remap.sv
module vpred_remap
  import vpred_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  localparam int IDX_W  = $clog2(NUM_ENTRIES),
  localparam int ELEM_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic              busy,
  input  logic              q_valid,
  input  logic              q_fp,
  input  logic [REG_W-1:0]  q_rd,
  input  logic [ELEM_W-1:0] q_elem,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              res_valid,
  output logic              res_pred,
  output logic              res_zero,
  output logic              res_en
);

  logic             rst_i_n;
  logic [IDX_W-1:0] walk_idx;
  cfg_ent_t         walk_ent;
  logic             walk_live;
  slot_t            int_tab [NUM_REGS];
  slot_t            fp_tab  [NUM_REGS];

  vpred_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  vpred_cfg_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .we      (cfg_we),
    .waddr   (cfg_idx),
    .wdata   (cfg_wdata),
    .rd_idx  (walk_idx),
    .rd_ent  (walk_ent),
    .rd_live (walk_live)
  );

  vpred_rebuild #(.NUM_ENTRIES(NUM_ENTRIES)) u_rebuild (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cfg_we   (cfg_we),
    .ent      (walk_ent),
    .ent_live (walk_live),
    .walk_idx (walk_idx),
    .busy     (busy),
    .int_tab  (int_tab),
    .fp_tab   (fp_tab)
  );

  vpred_query #(.XLEN(XLEN)) u_query (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .busy      (busy),
    .q_valid   (q_valid),
    .q_fp      (q_fp),
    .q_rd      (q_rd),
    .q_elem    (q_elem),
    .int_tab   (int_tab),
    .fp_tab    (fp_tab),
    .rf_raddr  (rf_raddr),
    .rf_rdata  (rf_rdata),
    .res_valid (res_valid),
    .res_pred  (res_pred),
    .res_zero  (res_zero),
    .res_en    (res_en)
  );

endmodule

// File: tb/vpred_remap_tb_top.sv
module vpred_remap_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [12:0] cfg_wdata;
  logic        busy;
  logic        q_valid, q_fp;
  logic [4:0]  q_rd, q_elem;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        res_valid, res_pred, res_zero, res_en;

  int total = 0;
  int bad   = 0;

  logic        m_live [16];
  logic [12:0] m_word [16];

  always #2.5 clk = ~clk;

  vpred_remap dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .busy(busy), .q_valid(q_valid), .q_fp(q_fp),
    .q_rd(q_rd), .q_elem(q_elem), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .res_valid(res_valid), .res_pred(res_pred), .res_zero(res_zero),
    .res_en(res_en)
  );

  function automatic logic [31:0] rf_val(input logic [4:0] r);
    return ({27'd0, r} * 32'h9E37_79B1) ^ (32'h5A5A_0000 >> r) ^ {r, 27'h1};
  endfunction

  assign rf_rdata = rf_val(rf_raddr);

  function automatic logic [12:0] enc(input logic z, input logic inv, input logic fp,
                                      input logic [4:0] pidx, input logic [4:0] tgt);
    return {pidx, z, inv, fp, tgt};
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [12:0] w);
    int cnt;
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = w;
    m_live[idx] = 1'b1; m_word[idx] = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == 17, "R3", "busy length after write", cnt, 17);
  endtask

  task automatic sweep(input string tag, input bit is_reset);
    for (int fp = 0; fp < 2; fp++) begin
      for (int rd = 0; rd < 32; rd++) begin
        for (int e = 0; e < 32; e++) begin
          logic found, ez, ei, ebit;
          logic [4:0] ep;
          found = 1'b0; ez = 1'b0; ei = 1'b0; ep = '0;
          for (int i = 0; i < 16; i++) begin
            if (m_live[i] && m_word[i][5] == fp[0] && m_word[i][4:0] == 5'(rd)) begin
              found = 1'b1; ez = m_word[i][7]; ei = m_word[i][6]; ep = m_word[i][12:8];
            end
          end
          ebit = found ? (rf_val(ep) >> e) & 1 ^ ei : 1'b1;
          q_valid = 1'b1; q_fp = fp[0]; q_rd = 5'(rd); q_elem = 5'(e);
          @(negedge clk);
          chk(res_valid === 1'b1, "R5", "res_valid", res_valid, 1);
          if (!found) begin
            chk(res_en === 1'b0 && res_pred === 1'b1 && res_zero === 1'b0,
                is_reset ? "R2" : {"R9 ", tag}, "disabled result {en,pred,zero}",
                {res_en, res_pred, res_zero}, 3'b010);
          end else begin
            chk(res_en === 1'b1, {"R6 ", tag}, "res_en", res_en, 1);
            chk(res_pred === ebit, {"R1 R7 ", tag}, "res_pred", res_pred, ebit);
            chk(res_zero === ez, {"R8 ", tag}, "res_zero", res_zero, ez);
          end
        end
      end
    end
    q_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_live[i] = 1'b0; m_word[i] = '0; end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    q_valid = 1'b0; q_fp = 1'b0; q_rd = '0; q_elem = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reset state
    chk(busy === 1'b0, "R2", "busy after reset", busy, 0);
    chk(res_valid === 1'b0, "R2", "res_valid after reset", res_valid, 0);
    sweep("R2", 1'b1);

    // R6 R7 R8 R10: mixed classes, duplicate destinations
    wr(0,  enc(1'b1, 1'b0, 1'b0, 5'd7,  5'd3));
    wr(1,  enc(1'b0, 1'b1, 1'b1, 5'd9,  5'd3));
    wr(2,  enc(1'b0, 1'b1, 1'b0, 5'd0,  5'd31));
    wr(5,  enc(1'b0, 1'b1, 1'b0, 5'd12, 5'd3));
    wr(15, enc(1'b1, 1'b1, 1'b1, 5'd31, 5'd0));
    wr(9,  enc(1'b1, 1'b0, 1'b1, 5'd20, 5'd17));
    sweep("R10", 1'b0);

    // R4: a query during a rebuild yields nothing
    cfg_we = 1'b1; cfg_idx = 4'd7; cfg_wdata = enc(1'b0, 1'b0, 1'b0, 5'd4, 5'd8);
    m_live[7] = 1'b1; m_word[7] = cfg_wdata;
    @(negedge clk);
    cfg_we = 1'b0; q_valid = 1'b1; q_rd = 5'd3; q_fp = 1'b0;
    @(negedge clk);
    chk(res_valid === 1'b0, "R4", "res_valid while busy", res_valid, 0);
    q_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R3: a second write during the rebuild restarts the count
    wr(7, enc(1'b0, 1'b0, 1'b0, 5'd4, 5'd8));

    // R11: move slot 5 away from destination 3
    wr(5, enc(1'b1, 1'b0, 1'b0, 5'd2, 5'd10));
    sweep("R11", 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule